// File: doc/BRIEF.md
# Cascadable Four-Bit ALU Slice

This block is a purely combinational arithmetic logic unit built from identical narrow slices. Each slice takes two operand words, a three-bit operation code and a carry input. It returns a result word, a carry output and a two's-complement overflow flag. The slice can add, subtract in either direction, and apply bitwise exclusive-or, or and and. Two further codes drive the result to all zeros or to all ones, whatever the operands are.

The top level places `NUM_SLICES` slices of `SLICE_W` bits side by side. Each slice's carry output feeds the carry input of the next more significant slice, so the chain acts as one wide ALU (16 bits with the default parameters). Subtraction adds the minuend to the bitwise complement of the subtrahend and to the carry input. To get a true difference, the caller holds the carry input at 1. A carry output of 1 after a subtraction therefore means that no borrow occurred. The overflow flag of the wide word comes from the top slice only.

Top module: `alu_ripple_chain`

## Requirements
- R1: Code 3'b000 drives the result to all zeros, with carry output 0 and overflow 0.
- R2: Code 3'b111 drives the result to all ones, with carry output 0 and overflow 0.
- R3: Code 3'b011 gives {carry_o, f_o} = a_i + b_i + carry_i, taking the operands as unsigned.
- R4: Code 3'b010 gives {carry_o, f_o} = a_i + ~b_i + carry_i. With carry_i = 1, f_o is a_i - b_i and carry_o is 1 exactly when a_i >= b_i (unsigned).
- R5: Code 3'b001 gives {carry_o, f_o} = b_i + ~a_i + carry_i. With carry_i = 1, f_o is b_i - a_i and carry_o is 1 exactly when b_i >= a_i (unsigned).
- R6: Codes 3'b100, 3'b101 and 3'b110 give the bitwise XOR, OR and AND of a_i and b_i, with carry output 0 and overflow 0.
- R7: In the three arithmetic codes, ovf_o is the XOR of the carry into the top result bit and the carry out of it. It is 1 exactly when the signed sum of the two steered operands and the carry input does not fit in the word width.
- R8: A chain of several slices behaves as one ALU of width SLICE_W*NUM_SLICES for every code. The carries ripple from slice to slice, and the overflow and carry output come from the most significant slice.
- R9: In the clear, preset and bitwise codes, carry_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | SLICE_W*NUM_SLICES | First operand |
| b_i | input | SLICE_W*NUM_SLICES | Second operand |
| sel_i | input | 3 | Operation code |
| carry_i | input | 1 | Carry into the least significant slice |
| f_o | output | SLICE_W*NUM_SLICES | Result word |
| carry_o | output | 1 | Carry out of the most significant slice |
| ovf_o | output | 1 | Two's-complement overflow of the whole word |

## Verification
The bench builds two copies of the block. The first is a single four-bit slice (NUM_SLICES = 1). It is small enough that every operand pair can be driven under every code with both carry-input values, so every carry and overflow pattern of one slice is covered. The second uses the default four-slice, 16-bit chain. Random and hand-picked operands there, including 16'h8000, 16'h7FFF and 16'hFFFF, push carries across all three slice boundaries and reach overflow only at the top slice.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

   typedef enum logic [2:0] {
      OP_ZERO  = 3'b000,
      OP_BSUBA = 3'b001,
      OP_ASUBB = 3'b010,
      OP_ADD   = 3'b011,
      OP_XOR   = 3'b100,
      OP_OR    = 3'b101,
      OP_AND   = 3'b110,
      OP_ONES  = 3'b111
   } alu_op_e;

   typedef enum logic [1:0] {
      SRC_FILL  = 2'd0,
      SRC_ARITH = 2'd1,
      SRC_BITOP = 2'd2
   } res_src_e;

   typedef enum logic [1:0] {
      BOP_XOR = 2'd0,
      BOP_OR  = 2'd1,
      BOP_AND = 2'd2
   } bit_op_e;

   typedef struct packed {
      res_src_e src;
      logic     fill;
      logic     inv_a;
      logic     inv_b;
      bit_op_e  bop;
   } alu_ctrl_t;

endpackage

// File: rtl/alu_mode_decode.sv
module alu_mode_decode
   import alu_slice_pkg::*;
(
   input  logic [2:0] sel_i,
   output alu_ctrl_t  ctrl_o
);

   always_comb begin
      ctrl_o.src   = SRC_FILL;
      ctrl_o.fill  = 1'b0;
      ctrl_o.inv_a = 1'b0;
      ctrl_o.inv_b = 1'b0;
      ctrl_o.bop   = BOP_XOR;
      case (alu_op_e'(sel_i))
         OP_ZERO:  ctrl_o.fill = 1'b0;
         OP_ONES:  ctrl_o.fill = 1'b1;
         OP_BSUBA: begin
            ctrl_o.src   = SRC_ARITH;
            ctrl_o.inv_a = 1'b1;
         end
         OP_ASUBB: begin
            ctrl_o.src   = SRC_ARITH;
            ctrl_o.inv_b = 1'b1;
         end
         OP_ADD:   ctrl_o.src = SRC_ARITH;
         OP_XOR: begin
            ctrl_o.src = SRC_BITOP;
            ctrl_o.bop = BOP_XOR;
         end
         OP_OR: begin
            ctrl_o.src = SRC_BITOP;
            ctrl_o.bop = BOP_OR;
         end
         OP_AND: begin
            ctrl_o.src = SRC_BITOP;
            ctrl_o.bop = BOP_AND;
         end
         default: ctrl_o.fill = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu_carry_chain.sv
module alu_carry_chain #(
   parameter int W      = 4,
   parameter bit LUMPED = 1'b0
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         c_i,
   output logic [W-1:0] sum_o,
   output logic         c_msb_o,
   output logic         c_o
);

   generate
      if (W < 2) begin : g_bad_width
         $error("alu_carry_chain: W must be at least 2");
      end

      if (LUMPED) begin : g_lumped
         logic [W:0] tot;
         assign tot     = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, c_i};
         assign sum_o   = tot[W-1:0];
         assign c_o     = tot[W];
         // the carry into the top bit is recovered from that bit's sum
         assign c_msb_o = tot[W-1] ^ x_i[W-1] ^ y_i[W-1];
      end else begin : g_ripple
         logic [W:0] c;
         assign c[0] = c_i;
         for (genvar i = 0; i < W; i++) begin : g_bit
            logic p;
            assign p        = x_i[i] ^ y_i[i];
            assign sum_o[i] = p ^ c[i];
            assign c[i+1]   = (x_i[i] & y_i[i]) | (p & c[i]);
         end
         assign c_msb_o = c[W-1];
         assign c_o     = c[W];
      end
   endgenerate

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
   import alu_slice_pkg::*;
#(
   parameter int W = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  bit_op_e      op_i,
   output logic [W-1:0] r_o
);

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_comb begin
            case (op_i)
               BOP_OR:  r_o[i] = a_i[i] | b_i[i];
               BOP_AND: r_o[i] = a_i[i] & b_i[i];
               default: r_o[i] = a_i[i] ^ b_i[i];
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/alu_slice.sv
module alu_slice
   import alu_slice_pkg::*;
#(
   parameter int W      = 4,
   parameter bit LUMPED = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [2:0]   sel_i,
   input  logic         c_i,
   output logic [W-1:0] f_o,
   output logic         c_o,
   output logic         ovf_o
);

   alu_ctrl_t  ctrl;
   logic [W-1:0] x_op, y_op, sum, bit_res;
   logic         c_msb, c_out;

   alu_mode_decode u_dec (
      .sel_i  (sel_i),
      .ctrl_o (ctrl)
   );

   assign x_op = ctrl.inv_a ? ~a_i : a_i;
   assign y_op = ctrl.inv_b ? ~b_i : b_i;

   alu_carry_chain #(.W(W), .LUMPED(LUMPED)) u_add (
      .x_i     (x_op),
      .y_i     (y_op),
      .c_i     (c_i),
      .sum_o   (sum),
      .c_msb_o (c_msb),
      .c_o     (c_out)
   );

   alu_bitwise #(.W(W)) u_bit (
      .a_i  (a_i),
      .b_i  (b_i),
      .op_i (ctrl.bop),
      .r_o  (bit_res)
   );

   always_comb begin
      case (ctrl.src)
         SRC_ARITH: begin
            f_o   = sum;
            c_o   = c_out;
            ovf_o = c_msb ^ c_out;
         end
         SRC_BITOP: begin
            f_o   = bit_res;
            c_o   = 1'b0;
            ovf_o = 1'b0;
         end
         default: begin
            f_o   = {W{ctrl.fill}};
            c_o   = 1'b0;
            ovf_o = 1'b0;
         end
      endcase
   end

   always_comb begin
      if (sel_i == 3'b000) begin
         // R1
         clear_result_chk: assert (f_o == '0 && !c_o && !ovf_o)
            else $error("clear code left a nonzero output");
      end
      if (sel_i == 3'b111) begin
         // R2
         preset_result_chk: assert (f_o == '1 && !c_o && !ovf_o)
            else $error("preset code did not give all ones");
      end
      if (sel_i == 3'b110) begin
         // R6
         and_result_chk: assert (f_o == (a_i & b_i))
            else $error("bitwise and mismatch");
      end
      if (sel_i[2] && sel_i != 3'b111) begin
         // R9
         bitop_flags_quiet_chk: assert (!c_o && !ovf_o)
            else $error("bitwise code raised a flag");
      end
      if (sel_i != 3'b000 && !sel_i[2]) begin
         // R7
         signed_overflow_chk: assert (ovf_o ==
               ((x_op[W-1] == y_op[W-1]) && (f_o[W-1] != x_op[W-1])))
            else $error("overflow flag disagrees with sign rule");
      end
   end

endmodule

// File: rtl/alu_ripple_chain.sv
module alu_ripple_chain #(
   parameter int SLICE_W    = 4,
   parameter int NUM_SLICES = 4,
   parameter bit LUMPED_ADD = 1'b0,
   localparam int TOT_W     = SLICE_W * NUM_SLICES
) (
   input  logic [TOT_W-1:0] a_i,
   input  logic [TOT_W-1:0] b_i,
   input  logic [2:0]       sel_i,
   input  logic             carry_i,
   output logic [TOT_W-1:0] f_o,
   output logic             carry_o,
   output logic             ovf_o
);

   logic [NUM_SLICES:0]   link;
   logic [NUM_SLICES-1:0] ovf_all;

   generate
      if (SLICE_W < 2) begin : g_bad_slice
         $error("alu_ripple_chain: SLICE_W must be at least 2");
      end
      if (NUM_SLICES < 1) begin : g_bad_count
         $error("alu_ripple_chain: NUM_SLICES must be at least 1");
      end
   endgenerate

   assign link[0] = carry_i;

   generate
      for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
         alu_slice #(.W(SLICE_W), .LUMPED(LUMPED_ADD)) u_slice (
            .a_i   (a_i[s*SLICE_W +: SLICE_W]),
            .b_i   (b_i[s*SLICE_W +: SLICE_W]),
            .sel_i (sel_i),
            .c_i   (link[s]),
            .f_o   (f_o[s*SLICE_W +: SLICE_W]),
            .c_o   (link[s+1]),
            .ovf_o (ovf_all[s])
         );
      end
   endgenerate

   assign carry_o = link[NUM_SLICES];
   assign ovf_o   = ovf_all[NUM_SLICES-1];

   always_comb begin
      if (sel_i[2] || sel_i == 3'b000) begin
         // R9
         slice_ovf_quiet_chk: assert (ovf_all == '0 && link[NUM_SLICES:1] == '0)
            else $error("a slice raised a flag outside arithmetic");
      end
      if (sel_i == 3'b100) begin
         // R8
         wide_xor_chk: assert (f_o == (a_i ^ b_i))
            else $error("wide xor mismatch");
      end
   end

endmodule

// File: tb/alu_ripple_chain_tb.sv
module alu_ripple_chain_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int n_checks = 0;
   int n_errors = 0;
   int cyc = 0;

   logic [15:0] a_w = '0, b_w = '0;
   logic [2:0]  sel_w = '0;
   logic        cin_w = 1'b0;
   logic [15:0] f_w;
   logic        co_w, ov_w;

   logic [3:0]  a_n = '0, b_n = '0;
   logic [2:0]  sel_n = '0;
   logic        cin_n = 1'b0;
   logic [3:0]  f_n;
   logic        co_n, ov_n;

   alu_ripple_chain u_dut (
      .a_i(a_w), .b_i(b_w), .sel_i(sel_w), .carry_i(cin_w),
      .f_o(f_w), .carry_o(co_w), .ovf_o(ov_w)
   );

   alu_ripple_chain #(.SLICE_W(4), .NUM_SLICES(1)) u_dut_slice (
      .a_i(a_n), .b_i(b_n), .sel_i(sel_n), .carry_i(cin_n),
      .f_o(f_n), .carry_o(co_n), .ovf_o(ov_n)
   );

   function automatic string mode_req(logic [2:0] s);
      case (s)
         3'b000: return "R1";
         3'b111: return "R2";
         3'b011: return "R3";
         3'b010: return "R4";
         3'b001: return "R5";
         default: return "R6";
      endcase
   endfunction

   // returns {ovf, carry, f[15:0]} for a word of width w
   function automatic logic [17:0] ref_model(int w, logic [2:0] s,
                                             logic [15:0] a, logic [15:0] b, logic cin);
      longint one = 1;
      longint mask = (one << w) - 1;
      longint half = one << (w - 1);
      longint ua = longint'(a) & mask;
      longint ub = longint'(b) & mask;
      longint sa = (ua >= half) ? ua - (one << w) : ua;
      longint sb = (ub >= half) ? ub - (one << w) : ub;
      longint ci = cin ? 1 : 0;
      longint tot = 0, st = 0, fr = 0;
      logic co = 1'b0, ov = 1'b0;
      case (s)
         3'b000: fr = 0;
         3'b111: fr = mask;
         3'b100: fr = ua ^ ub;
         3'b101: fr = ua | ub;
         3'b110: fr = ua & ub;
         default: begin
            if (s == 3'b011) begin
               tot = ua + ub + ci;
               st = sa + sb + ci;
            end else if (s == 3'b010) begin
               tot = ua + ((~ub) & mask) + ci;
               st = sa - sb - 1 + ci;
            end else begin
               tot = ub + ((~ua) & mask) + ci;
               st = sb - sa - 1 + ci;
            end
            fr = tot & mask;
            co = ((tot >> w) & 1) != 0;
            ov = (st < -half) || (st > half - 1);
         end
      endcase
      return {ov, co, fr[15:0]};
   endfunction

   task automatic check(string req, logic [17:0] got, logic [17:0] exp);
      n_checks++;
      if (got[16:0] !== exp[16:0]) begin
         n_errors++;
         $display("FAIL %s: {carry,f} got %0h expected %0h", req, got[16:0], exp[16:0]);
      end
      n_checks++;
      if (got[17] !== exp[17]) begin
         n_errors++;
         $display("FAIL R7 (%s): overflow got %0b expected %0b", req, got[17], exp[17]);
      end
   endtask

   task automatic apply_wide(logic [2:0] s, logic [15:0] a, logic [15:0] b, logic cin);
      @(posedge clk);
      #1;
      sel_w = s; a_w = a; b_w = b; cin_w = cin;
      @(negedge clk);
   endtask

   task automatic run_wide(logic [2:0] s, logic [15:0] a, logic [15:0] b, logic cin);
      apply_wide(s, a, b, cin);
      check({"R8 ", mode_req(s)}, {ov_w, co_w, f_w}, ref_model(16, s, a, b, cin));
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: all inputs zero and code 000 leave every output low
      check("R1 reset", {ov_w, co_w, f_w}, 18'd0);
      check("R1 reset", {ov_n, co_n, 12'd0, f_n}, 18'd0);
   endtask

   task automatic t_exhaustive_slice();
      for (int s = 0; s < 8; s++) begin
         for (int v = 0; v < 512; v++) begin
            @(posedge clk);
            #1;
            sel_n = 3'(s); a_n = v[3:0]; b_n = v[7:4]; cin_n = v[8];
            @(negedge clk);
            check(mode_req(3'(s)), {ov_n, co_n, 12'd0, f_n},
                  ref_model(4, 3'(s), {12'd0, v[3:0]}, {12'd0, v[7:4]}, v[8]));
         end
      end
   endtask

   task automatic t_random_wide();
      for (int s = 0; s < 8; s++) begin
         for (int k = 0; k < 200; k++) begin
            run_wide(3'(s), 16'($urandom), 16'($urandom), 1'($urandom));
         end
      end
   endtask

   task automatic t_edges_wide();
      logic [15:0] edge_val [6] = '{16'h0000, 16'h0001, 16'h7FFF,
                                    16'h8000, 16'hFFFF, 16'h00FF};
      for (int s = 0; s < 8; s++) begin
         for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
               run_wide(3'(s), edge_val[i], edge_val[j], 1'b0);
               run_wide(3'(s), edge_val[i], edge_val[j], 1'b1);
            end
         end
      end
      // R4: 0x8000 - 1 overflows; R3: 0x7FFF + 1 overflows; R5: 0 - 0x8000 overflows
      run_wide(3'b010, 16'h8000, 16'h0001, 1'b1);
      run_wide(3'b011, 16'h7FFF, 16'h0001, 1'b0);
      run_wide(3'b001, 16'h8000, 16'h0000, 1'b1);
   endtask

   task automatic t_carry_ignored();
      logic [2:0] codes [5] = '{3'b000, 3'b100, 3'b101, 3'b110, 3'b111};
      for (int c = 0; c < 5; c++) begin
         for (int k = 0; k < 20; k++) begin
            logic [15:0] a = 16'($urandom);
            logic [15:0] b = 16'($urandom);
            logic [17:0] first;
            apply_wide(codes[c], a, b, 1'b0);
            first = {ov_w, co_w, f_w};
            apply_wide(codes[c], a, b, 1'b1);
            // R9: the second result must match the first and the model
            check("R9", {ov_w, co_w, f_w}, first);
            check("R9", {ov_w, co_w, f_w}, ref_model(16, codes[c], a, b, 1'b1));
         end
      end
   endtask

   initial begin : watchdog
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin : main
      t_reset_state();
      t_exhaustive_slice();
      t_random_wide();
      t_edges_wide();
      t_carry_ignored();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule